// File: doc/BRIEF.md
# Index/Data Configuration Port Controller

This block implements a locked configuration space that a host reaches through a pair of byte-wide I/O addresses: an index port that selects a register and a data port, one address above it, that reads or writes the selected register. The host bus is simple: an address, a write strobe, a read strobe and 8-bit write and read data. Out of reset the space is locked. While locked, writes to the index port are only compared against an unlock key, and the data port is inert.

Two key styles exist, chosen by a parameter. The short style unlocks on two identical key bytes and relocks on a single exit byte written to the index port. The long style unlocks on a four-byte key and relocks only when a particular value is written to a control register. The long style works only at the primary port pair. Once unlocked, the host sees global registers (logical-device select, a 16-bit chip ID and, in the short style, a vendor ID word). It also sees a four-byte window onto a per-logical-device bank that holds a primary and a secondary base address. The window follows the device selected in the select register.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is 0x2E and the data port 0x2F when ALT_PORT is 0, and 0x4E/0x4F when ALT_PORT is 1. Accesses to any other address have no effect, and a read of another address leaves bus_rdata unchanged.
- R2: After reset the block is locked. While locked, reads of the index or data port return 0xFF and data-port writes are ignored: a value written to the data port then is not found in the device-select register after unlock.
- R3: With KEY_STYLE 0, two consecutive index writes of 0x87 unlock the block. An index write of 0xAA while unlocked locks it again. Writes of 0xAA to any address other than the index port do not lock it.
- R4: With KEY_STYLE 1, the index-write sequence 0x87, 0x01, 0x55, 0x55 unlocks the block, and the first three bytes alone do not. While unlocked, writing 0x02 to register 0x02 locks it, and writing any other value there does not.
- R5: With KEY_STYLE 1 and ALT_PORT 1, the block never unlocks.
- R6: A key byte that does not match the expected next byte restarts the key. If that byte is 0x87, it counts as the first byte of a new attempt, so 0x87, 0x12, 0x87, 0x87 unlocks in style 0 but 0x87, 0x12, 0x87 does not.
- R7: Register 0x07 holds the selected logical-device number and reads back what was written. Registers 0x60 to 0x63 access the bank of the selected device. Another device's bank is unaffected by the write. A device number at or above NUM_LDEV reads 0xFF in the window, and writes to it are discarded.
- R8: Register 0x20 reads CHIP_ID[15:8] and register 0x21 reads CHIP_ID[7:0], which is the revision byte. In style 0, registers 0x23 and 0x24 read VENDOR_ID[15:8] and VENDOR_ID[7:0]. In style 1, they read 0xFF.
- R9: Device n resets to a primary base of PRI_BASE + 16*n at 0x60 (high byte) and 0x61 (low byte), and to a secondary base of SEC_BASE + 16*n at 0x62/0x63. Writes to the window replace the addressed byte.
- R10: bus_rdata takes the read value on the clock edge that samples bus_rd and holds it until the next port read. Reads have no side effects, so two successive reads of the same register return the same byte.
- R11: While unlocked, an index-port read returns the current index. Unassigned registers read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address of the current access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while the configuration space is unlocked |

## Verification
Three instances are driven: style 0 on the primary pair, style 1 on the primary pair, and style 1 on the alternate pair. Key patterns include the full keys, truncated keys and a broken key that restarts on 0x87. Together they separate a matcher that restarts correctly from one that drops the restarting byte or accepts a prefix. A sweep over every device number up to one past the last reads all four window bytes and compares them with base values computed arithmetically, which catches wrong device strides, swapped high and low bytes and missing out-of-range handling. Writes to one device, the exit commands and accesses to foreign addresses then show what changes and what must stay put.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam logic [7:0] REG_CTRL   = 8'h02;
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ID_HI  = 8'h20;
  localparam logic [7:0] REG_ID_LO  = 8'h21;
  localparam logic [7:0] REG_VEN_HI = 8'h23;
  localparam logic [7:0] REG_VEN_LO = 8'h24;
  localparam logic [5:0] REG_WIN_Q  = 6'h18;  // 0x60..0x63 >> 2
  localparam logic [7:0] EXIT_SHORT = 8'hAA;
  localparam logic [7:0] EXIT_LONG  = 8'h02;
  localparam logic [7:0] NO_DATA    = 8'hFF;

  typedef enum int {KEY_SHORT = 0, KEY_LONG = 1} key_style_e;

  function automatic int key_len(input int style);
    return (style == KEY_SHORT) ? 2 : 4;
  endfunction

  function automatic logic [7:0] key_byte(input int style, input logic [1:0] step);
    if (style == KEY_SHORT) return 8'h87;
    case (step)
      2'd0:    return 8'h87;
      2'd1:    return 8'h01;
      default: return 8'h55;
    endcase
  endfunction

  // Byte sel of a device's reset base word: sel[1] picks secondary, sel[0] picks low byte.
  function automatic logic [7:0] base_byte(input logic [15:0] pri, input logic [15:0] sec,
                                            input int stride, input int dev, input int sel);
    logic [15:0] w;
    w = ((sel & 2) != 0 ? sec : pri) + 16'(dev * stride);
    return ((sel & 1) != 0) ? w[7:0] : w[15:8];
  endfunction

endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
#(
  parameter int KEY_STYLE = 0,
  parameter bit ENABLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       exit_req,
  output logic       mode
);
  localparam int KLEN = key_len(KEY_STYLE);
  localparam logic [1:0] LAST = 2'(KLEN - 1);

  logic [1:0] step;
  logic       hit;

  assign hit = (key_data == key_byte(KEY_STYLE, step));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= 1'b0;
      step <= 2'd0;
    end else if (exit_req) begin
      mode <= 1'b0;
      step <= 2'd0;
    end else if (key_wr && ENABLE) begin
      if (hit) begin
        if (step == LAST) begin
          mode <= 1'b1;
          step <= 2'd0;
        end else begin
          step <= step + 2'd1;
        end
      end else begin
        step <= (key_data == key_byte(KEY_STYLE, 2'd0)) ? 2'd1 : 2'd0;
      end
    end
  end
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDEV   = 4,
  parameter logic [15:0] PRI_BASE   = 16'h0290,
  parameter logic [15:0] SEC_BASE   = 16'h0800,
  parameter int          DEV_STRIDE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] ldn,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic [7:0] rbyte
);
  localparam int SLOTS = NUM_LDEV * 4;
  localparam int AW    = $clog2(SLOTS);

  logic [7:0]    mem [SLOTS];
  logic          dev_ok;
  logic [AW-1:0] slot;

  assign dev_ok = (int'(ldn) < NUM_LDEV);
  assign slot   = AW'({ldn, sel});
  assign rbyte  = dev_ok ? mem[slot] : NO_DATA;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++)
        mem[i] <= base_byte(PRI_BASE, SEC_BASE, DEV_STRIDE, i / 4, i % 4);
    end else if (we && dev_ok) begin
      mem[slot] <= wdata;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter bit          ALT_PORT  = 1'b0,
  parameter int          KEY_STYLE = 0,
  parameter int          NUM_LDEV  = 4,
  parameter logic [15:0] CHIP_ID   = 16'hC560,
  parameter logic [15:0] VENDOR_ID = 16'h5A3C,
  parameter logic [15:0] PRI_BASE  = 16'h0290,
  parameter logic [15:0] SEC_BASE  = 16'h0800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cfg_mode
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ALT_PORT ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + ADDR_W'(1);
  localparam bit KEY_OK = !((KEY_STYLE == KEY_LONG) && ALT_PORT);

  logic       idx_hit, dat_hit, exit_req, key_wr, win_sel;
  logic [7:0] cfg_index, ldn_q, win_byte, rd_val;

  assign idx_hit = (bus_addr == IDX_ADDR);
  assign dat_hit = (bus_addr == DAT_ADDR);
  assign key_wr  = bus_wr && idx_hit && !cfg_mode;
  assign win_sel = (cfg_index[7:2] == REG_WIN_Q);

  generate
    if (KEY_STYLE == KEY_SHORT) begin : g_exit_short
      assign exit_req = cfg_mode && bus_wr && idx_hit && (bus_wdata == EXIT_SHORT);
    end else begin : g_exit_long
      assign exit_req = cfg_mode && bus_wr && dat_hit && (cfg_index == REG_CTRL) &&
                        (bus_wdata == EXIT_LONG);
    end
  endgenerate

  sio_key_seq #(.KEY_STYLE(KEY_STYLE), .ENABLE(KEY_OK)) u_key (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_data(bus_wdata),
    .exit_req(exit_req), .mode(cfg_mode)
  );

  sio_ldev_bank #(.NUM_LDEV(NUM_LDEV), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE),
                  .DEV_STRIDE(16)) u_bank (
    .clk(clk), .rst(rst),
    .we(cfg_mode && bus_wr && dat_hit && win_sel),
    .ldn(ldn_q), .sel(cfg_index[1:0]), .wdata(bus_wdata), .rbyte(win_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_index <= 8'h00;
      ldn_q     <= 8'h00;
    end else if (cfg_mode && bus_wr) begin
      if (idx_hit && !exit_req) cfg_index <= bus_wdata;
      if (dat_hit && cfg_index == REG_LDN) ldn_q <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = NO_DATA;
    if (cfg_mode) begin
      if (idx_hit) rd_val = cfg_index;
      else if (win_sel) rd_val = win_byte;
      else begin
        case (cfg_index)
          REG_LDN:    rd_val = ldn_q;
          REG_ID_HI:  rd_val = CHIP_ID[15:8];
          REG_ID_LO:  rd_val = CHIP_ID[7:0];
          REG_VEN_HI: rd_val = (KEY_STYLE == KEY_SHORT) ? VENDOR_ID[15:8] : NO_DATA;
          REG_VEN_LO: rd_val = (KEY_STYLE == KEY_SHORT) ? VENDOR_ID[7:0] : NO_DATA;
          default:    rd_val = NO_DATA;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= NO_DATA;
    else if (bus_rd && (idx_hit || dat_hit)) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int ADDR_W    = 16,
  parameter bit ALT_PORT  = 1'b0,
  parameter int KEY_STYLE = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              cfg_mode
);
  localparam logic [ADDR_W-1:0] IDX = ALT_PORT ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
  localparam logic [ADDR_W-1:0] DAT = IDX + ADDR_W'(1);

  p_locked_read_ff_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == IDX || bus_addr == DAT) && !cfg_mode) |=> (bus_rdata == 8'hFF));

  p_lock_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && !(bus_wr && bus_addr == IDX)) |=> !cfg_mode);

  p_unlock_source_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(bus_wr && bus_addr == IDX));

  p_exit_short_r3: assert property (@(posedge clk) disable iff (rst)
    (KEY_STYLE == 0 && cfg_mode && bus_wr && bus_addr == IDX && bus_wdata == 8'hAA) |=> !cfg_mode);

  p_alt_long_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (KEY_STYLE == 1 && ALT_PORT) |-> !cfg_mode);

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && (bus_addr == IDX || bus_addr == DAT)) |=> $stable(bus_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .ALT_PORT(ALT_PORT), .KEY_STYLE(KEY_STYLE)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode(cfg_mode)
);

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  localparam logic [15:0] PRI = 16'h0290;
  localparam logic [15:0] SEC = 16'h0800;
  localparam int NLD = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] addr = 16'h0;
  logic wr_a = 0, wr_b = 0, wr_c = 0, rd = 0;
  logic [7:0] wdata = 8'h0;
  logic [7:0] rdata_a, rdata_b, rdata_c;
  logic mode_a, mode_b, mode_c;
  int checks = 0, errors = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  sio_cfg_port #(.ALT_PORT(1'b0), .KEY_STYLE(0), .NUM_LDEV(NLD), .PRI_BASE(PRI), .SEC_BASE(SEC)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_a), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .cfg_mode(mode_a));
  sio_cfg_port #(.ALT_PORT(1'b0), .KEY_STYLE(1), .NUM_LDEV(NLD), .PRI_BASE(PRI), .SEC_BASE(SEC)) uut_b (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_b), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .cfg_mode(mode_b));
  sio_cfg_port #(.ALT_PORT(1'b1), .KEY_STYLE(1), .NUM_LDEV(NLD), .PRI_BASE(PRI), .SEC_BASE(SEC)) uut_c (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_c), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata_c), .cfg_mode(mode_c));

  task automatic bw(input int s, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    wr_a = (s == 0); wr_b = (s == 1); wr_c = (s == 2);
    @(negedge clk);
    wr_a = 0; wr_b = 0; wr_c = 0;
  endtask

  task automatic br(input int s, input logic [15:0] a, output logic [7:0] r);
    @(negedge clk);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    r = (s == 0) ? rdata_a : (s == 1) ? rdata_b : rdata_c;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_win(input int l, input int s);
    logic [15:0] w;
    if (l >= NLD) return 8'hFF;
    w = ((s >= 2) ? SEC : PRI) + 16'(l * 16);
    return (s % 2 == 1) ? w[7:0] : w[15:8];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R2: locked after reset
    br(0, 16'h2F, v); chk("R2 locked data read", v, 8'hFF);
    br(0, 16'h2E, v); chk("R2 locked index read", v, 8'hFF);
    bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'h03);
    // R6: broken key restarts on 0x87
    bw(0, 16'h2E, 8'h87); bw(0, 16'h2E, 8'h12); bw(0, 16'h2E, 8'h87);
    br(0, 16'h2E, v); chk("R6 partial key stays locked", v, 8'hFF);
    bw(0, 16'h2E, 8'h87);
    br(0, 16'h2E, v); chk("R6 R3 unlocked index read R11", v, 8'h00);
    // R2: data write while locked was dropped
    bw(0, 16'h2E, 8'h07);
    br(0, 16'h2F, v); chk("R2 locked write ignored", v, 8'h00);
    // R8 IDs
    bw(0, 16'h2E, 8'h20); br(0, 16'h2F, v); chk("R8 chip id hi", v, 8'hC5);
    bw(0, 16'h2E, 8'h21); br(0, 16'h2F, v); chk("R8 chip id lo", v, 8'h60);
    bw(0, 16'h2E, 8'h23); br(0, 16'h2F, v); chk("R8 vendor hi", v, 8'h5A);
    bw(0, 16'h2E, 8'h24); br(0, 16'h2F, v); chk("R8 vendor lo", v, 8'h3C);
    bw(0, 16'h2E, 8'h25); br(0, 16'h2F, v); chk("R11 unassigned", v, 8'hFF);
    // R7 R9 sweep over devices including one out of range
    for (int l = 0; l <= NLD; l++) begin
      bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'(l));
      br(0, 16'h2F, v); chk("R7 ldn readback", v, 8'(l));
      for (int s = 0; s < 4; s++) begin
        bw(0, 16'h2E, 8'(8'h60 + s));
        br(0, 16'h2F, v); chk("R9 R7 window reset value", v, exp_win(l, s));
      end
    end
    // R9 write, R10 repeat read
    bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'h02);
    bw(0, 16'h2E, 8'h61); bw(0, 16'h2F, 8'hA8);
    br(0, 16'h2F, v); chk("R9 window write", v, 8'hA8);
    br(0, 16'h2F, v); chk("R10 repeat read", v, 8'hA8);
    bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'h01);
    bw(0, 16'h2E, 8'h61); br(0, 16'h2F, v); chk("R7 other device untouched", v, 8'hA0);
    bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'h04);
    bw(0, 16'h2E, 8'h60); bw(0, 16'h2F, 8'h33);
    br(0, 16'h2F, v); chk("R7 out-of-range device", v, 8'hFF);
    bw(0, 16'h2E, 8'h07); bw(0, 16'h2F, 8'h03);
    bw(0, 16'h2E, 8'h60); br(0, 16'h2F, v); chk("R7 dev3 untouched", v, 8'h02);
    // R1 foreign addresses
    br(0, 16'h4F, v); chk("R1 foreign read holds rdata", v, 8'h02);
    bw(0, 16'h4E, 8'hAA);
    br(0, 16'h2E, v); chk("R1 R3 foreign exit ignored", v, 8'h60);
    // R3 exit
    bw(0, 16'h2E, 8'hAA);
    br(0, 16'h2F, v); chk("R3 relocked data", v, 8'hFF);
    br(0, 16'h2E, v); chk("R3 relocked index", v, 8'hFF);
    // R4 long key
    bw(1, 16'h2E, 8'h87); bw(1, 16'h2E, 8'h01); bw(1, 16'h2E, 8'h55);
    br(1, 16'h2E, v); chk("R4 three-byte prefix rejected", v, 8'hFF);
    bw(1, 16'h2E, 8'h55);
    br(1, 16'h2E, v); chk("R4 full key unlocks", v, 8'h00);
    bw(1, 16'h2E, 8'h20); br(1, 16'h2F, v); chk("R8 long style chip id", v, 8'hC5);
    bw(1, 16'h2E, 8'h23); br(1, 16'h2F, v); chk("R8 long style no vendor", v, 8'hFF);
    bw(1, 16'h2E, 8'h02); bw(1, 16'h2F, 8'h01);
    br(1, 16'h2E, v); chk("R4 wrong exit value", v, 8'h02);
    bw(1, 16'h2F, 8'h02);
    br(1, 16'h2E, v); chk("R4 exit relocks", v, 8'hFF);
    // R5 long key on alternate pair
    bw(2, 16'h4E, 8'h87); bw(2, 16'h4E, 8'h01); bw(2, 16'h4E, 8'h55); bw(2, 16'h4E, 8'h55);
    br(2, 16'h4E, v); chk("R5 alt long index", v, 8'hFF);
    br(2, 16'h4F, v); chk("R5 alt long data", v, 8'hFF);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule